// File: doc/BRIEF.md
# Power domain switch sequencer

This block brings one switchable power island up and down in a fixed, mirrored order. A controller pulses an on or off request. The sequencer then steps the island's control outputs one change per step: two staged power-switch enables, isolation, an active-low island reset, a clock gate, and a group of memory power-down lines. It also drives a bus fence request toward the interconnect. Between steps it waits on feedback: two power-status lines, the memory power-down acknowledges, and the fence acknowledge.

Every wait has a cycle-count limit. When the limit runs out, the sequence stops where it is and reports an error. The controller can retry with a fresh request. Three parameters set the island's shape:
- the number of memory banks;
- which bank acknowledges exist;
- whether the island sits behind a bus fence.

Top module: `pwr_domain_seq`

## Requirements
- R1: On power-up, `sw_en_a` rises first and `sw_en_b` rises in a later cycle. Only after both does the block begin waiting on the status lines.
- R2: Power counts as present only when `pwr_stat_a` and `pwr_stat_b` are both 1, and as gone only when both are 0. If exactly one is high, neither wait is satisfied, and a wait held in that state ends in a timeout.
- R3: Once power is present, each of the following happens in its own later cycle, in this order: `clk_gate` goes to 0, then `iso_en` goes to 0, then `dom_rst_n` goes to 1, then every `mem_pd` bit goes to 0.
- R4: After clearing `mem_pd`, power-up waits until every acknowledge bit selected by `MEM_ACK_MASK` reads 0. Bits outside the mask are ignored. When the mask is all zero, this wait is skipped.
- R5: With `HAS_FENCE`=1, the bus fence works as follows:
  - The last power-up step drops `bus_fence_req` and waits for `bus_fence_ack`=0.
  - The first power-down step raises `bus_fence_req` and waits for `bus_fence_ack`=1.
  - With `HAS_FENCE`=0, `bus_fence_req` stays 0 and `bus_fence_ack` is ignored.
- R6: On power-down, after the fence step, all `mem_pd` bits are set. The block then waits until every masked acknowledge bit reads 1; with an empty mask this wait is skipped.
- R7: Power-down then proceeds in order, one change per later cycle:
  1. `iso_en` goes to 1.
  2. `dom_rst_n` goes to 0.
  3. `clk_gate` goes to 1.
  4. `sw_en_a` goes to 0.
  5. `sw_en_b` goes to 0.
  
  After the last step, the block waits for both status lines to read 0.
- R8: Any single wait that lasts `TIMEOUT_CYC` cycles without being satisfied aborts the sequence. On abort:
  - `err` pulses for one cycle, and `done` is not given.
  - `busy` drops.
  - All outputs keep their current values, and the recorded island state is unchanged.
- R9: After reset, the outputs are:
  - `sw_en_a`=0 and `sw_en_b`=0;
  - `iso_en`=1, `dom_rst_n`=0, `clk_gate`=1;
  - `mem_pd` all ones;
  - `bus_fence_req`=`HAS_FENCE`;
  - `busy`=0, `done`=0, `err`=0.
- R10: `busy` is 1 from the cycle after an accepted request until the sequence ends. `done` pulses for one cycle when a sequence completes. Requests that arrive while `busy` is 1 are ignored.
- R11: A request for the state the island already holds makes `done` pulse in the cycle after the request. In that case `busy` stays 0 and no output changes. If `on_req` and `off_req` are high together, `on_req` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| on_req | input | 1 | Request to power the island up (one-cycle pulse) |
| off_req | input | 1 | Request to power the island down (one-cycle pulse) |
| pwr_stat_a | input | 1 | First power-status feedback |
| pwr_stat_b | input | 1 | Second power-status feedback |
| mem_pd_ack | input | MEM_BANKS | Memory power-down acknowledges |
| bus_fence_ack | input | 1 | Bus fence acknowledge |
| sw_en_a | output | 1 | First-stage power-switch enable |
| sw_en_b | output | 1 | Second-stage power-switch enable |
| iso_en | output | 1 | Output isolation enable |
| dom_rst_n | output | 1 | Island reset, active low |
| clk_gate | output | 1 | Island clock disable |
| mem_pd | output | MEM_BANKS | Memory power-down controls |
| bus_fence_req | output | 1 | Bus fence request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle timeout pulse |

## Verification
Two things can coincide with a request. An on and an off request can land in the same cycle. A request can also arrive while a sequence is still stepping. The bench pulses both requests together from the off state and judges the result by a complete power-up ending in the on output pattern. It also injects an opposing request a few cycles into a power-down, checks that `busy` is high at that moment, and confirms that the island still ends fully off. A random run repeats both collisions against a bench model of the island state.

// File: rtl/pds_pkg.sv
package pds_pkg;

  typedef enum logic [4:0] {
    S_IDLE,
    S_UP_EN_A,
    S_UP_EN_B,
    S_UP_WPWR,
    S_UP_CLK,
    S_UP_ISO,
    S_UP_RST,
    S_UP_MEM,
    S_UP_WMEM,
    S_UP_FENCE,
    S_UP_WFENCE,
    S_DN_FENCE,
    S_DN_WFENCE,
    S_DN_MEM,
    S_DN_WMEM,
    S_DN_ISO,
    S_DN_RST,
    S_DN_CLK,
    S_DN_EN_A,
    S_DN_EN_B,
    S_DN_WPWR
  } seq_state_e;

endpackage

// File: rtl/pds_ack_eval.sv
module pds_ack_eval #(
  parameter int                   MEM_BANKS    = 4,
  parameter logic [MEM_BANKS-1:0] MEM_ACK_MASK = '1
) (
  input  logic                 stat_a,
  input  logic                 stat_b,
  input  logic [MEM_BANKS-1:0] mem_ack,
  output logic                 pwr_present,
  output logic                 pwr_gone,
  output logic                 mem_all_clr,
  output logic                 mem_all_set
);

  logic [MEM_BANKS-1:0] masked;

  assign masked      = mem_ack & MEM_ACK_MASK;
  // a single high status line is transitional and satisfies neither wait
  assign pwr_present = stat_a & stat_b;
  assign pwr_gone    = ~stat_a & ~stat_b;
  assign mem_all_clr = (masked == '0);
  assign mem_all_set = (masked == MEM_ACK_MASK);

endmodule

// File: rtl/pds_wait_timer.sv
module pds_wait_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ok,
  output logic expired
);

  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired = run & ~ok & (cnt_q == CNT_W'(LIMIT - 1));
  assign cnt_en  = run | (cnt_q != '0);

  always_comb begin
    if (run && !ok) cnt_d = cnt_q + 1'b1;
    else            cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq #(
  parameter int                   MEM_BANKS    = 4,
  parameter logic [MEM_BANKS-1:0] MEM_ACK_MASK = '1,
  parameter bit                   HAS_FENCE    = 1'b1,
  parameter int                   TIMEOUT_CYC  = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 on_req,
  input  logic                 off_req,
  input  logic                 pwr_stat_a,
  input  logic                 pwr_stat_b,
  input  logic [MEM_BANKS-1:0] mem_pd_ack,
  input  logic                 bus_fence_ack,
  output logic                 sw_en_a,
  output logic                 sw_en_b,
  output logic                 iso_en,
  output logic                 dom_rst_n,
  output logic                 clk_gate,
  output logic [MEM_BANKS-1:0] mem_pd,
  output logic                 bus_fence_req,
  output logic                 busy,
  output logic                 done,
  output logic                 err
);

  import pds_pkg::*;

  localparam bit HAS_MEM_ACK = |MEM_ACK_MASK;

  seq_state_e           state_q, state_d;
  logic                 en_a_q, en_a_d, en_b_q, en_b_d;
  logic                 iso_q, iso_d, rstn_q, rstn_d, gate_q, gate_d;
  logic [MEM_BANKS-1:0] pd_q, pd_d;
  logic                 fence_q, fence_d;
  logic                 on_q, on_d, done_q, done_d, err_q, err_d;
  logic                 ctrl_en;

  logic pwr_present, pwr_gone, mem_all_clr, mem_all_set;
  logic wait_run, wait_ok, tmo;
  logic fin_up, fin_dn;

  pds_ack_eval #(
    .MEM_BANKS   (MEM_BANKS),
    .MEM_ACK_MASK(MEM_ACK_MASK)
  ) u_ack (
    .stat_a     (pwr_stat_a),
    .stat_b     (pwr_stat_b),
    .mem_ack    (mem_pd_ack),
    .pwr_present(pwr_present),
    .pwr_gone   (pwr_gone),
    .mem_all_clr(mem_all_clr),
    .mem_all_set(mem_all_set)
  );

  pds_wait_timer #(
    .LIMIT(TIMEOUT_CYC)
  ) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (wait_run),
    .ok     (wait_ok),
    .expired(tmo)
  );

  // wait condition for the current state
  always_comb begin
    wait_run = 1'b1;
    wait_ok  = 1'b0;
    unique case (state_q)
      S_UP_WPWR:   wait_ok = pwr_present;
      S_UP_WMEM:   wait_ok = mem_all_clr;
      S_UP_WFENCE: wait_ok = ~bus_fence_ack;
      S_DN_WFENCE: wait_ok = bus_fence_ack;
      S_DN_WMEM:   wait_ok = mem_all_set;
      S_DN_WPWR:   wait_ok = pwr_gone;
      default:     wait_run = 1'b0;
    endcase
  end

  // next-state and next-control logic
  always_comb begin
    state_d = state_q;
    en_a_d  = en_a_q;
    en_b_d  = en_b_q;
    iso_d   = iso_q;
    rstn_d  = rstn_q;
    gate_d  = gate_q;
    pd_d    = pd_q;
    fence_d = fence_q;
    on_d    = on_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    fin_up  = 1'b0;
    fin_dn  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (on_req) begin
          if (on_q) done_d  = 1'b1;
          else      state_d = S_UP_EN_A;
        end else if (off_req) begin
          if (!on_q)          done_d  = 1'b1;
          else if (HAS_FENCE) state_d = S_DN_FENCE;
          else                state_d = S_DN_MEM;
        end
      end
      S_UP_EN_A: begin en_a_d = 1'b1; state_d = S_UP_EN_B; end
      S_UP_EN_B: begin en_b_d = 1'b1; state_d = S_UP_WPWR; end
      S_UP_WPWR: if (wait_ok) state_d = S_UP_CLK;
      S_UP_CLK:  begin gate_d = 1'b0; state_d = S_UP_ISO; end
      S_UP_ISO:  begin iso_d  = 1'b0; state_d = S_UP_RST; end
      S_UP_RST:  begin rstn_d = 1'b1; state_d = S_UP_MEM; end
      S_UP_MEM: begin
        pd_d = '0;
        if (HAS_MEM_ACK)    state_d = S_UP_WMEM;
        else if (HAS_FENCE) state_d = S_UP_FENCE;
        else                fin_up  = 1'b1;
      end
      S_UP_WMEM: if (wait_ok) begin
        if (HAS_FENCE) state_d = S_UP_FENCE;
        else           fin_up  = 1'b1;
      end
      S_UP_FENCE:  begin fence_d = 1'b0; state_d = S_UP_WFENCE; end
      S_UP_WFENCE: if (wait_ok) fin_up = 1'b1;
      S_DN_FENCE:  begin fence_d = 1'b1; state_d = S_DN_WFENCE; end
      S_DN_WFENCE: if (wait_ok) state_d = S_DN_MEM;
      S_DN_MEM: begin
        pd_d = '1;
        if (HAS_MEM_ACK) state_d = S_DN_WMEM;
        else             state_d = S_DN_ISO;
      end
      S_DN_WMEM: if (wait_ok) state_d = S_DN_ISO;
      S_DN_ISO:  begin iso_d  = 1'b1; state_d = S_DN_RST;  end
      S_DN_RST:  begin rstn_d = 1'b0; state_d = S_DN_CLK;  end
      S_DN_CLK:  begin gate_d = 1'b1; state_d = S_DN_EN_A; end
      S_DN_EN_A: begin en_a_d = 1'b0; state_d = S_DN_EN_B; end
      S_DN_EN_B: begin en_b_d = 1'b0; state_d = S_DN_WPWR; end
      S_DN_WPWR: if (wait_ok) fin_dn = 1'b1;
      default:   state_d = S_IDLE;
    endcase
    if (fin_up || fin_dn) begin
      state_d = S_IDLE;
      done_d  = 1'b1;
      on_d    = fin_up;
    end
    if (tmo) begin
      state_d = S_IDLE;
      err_d   = 1'b1;
    end
  end

  // control outputs only move while a sequence runs
  assign ctrl_en = (state_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      on_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
      on_q    <= on_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_a_q  <= 1'b0;
      en_b_q  <= 1'b0;
      iso_q   <= 1'b1;
      rstn_q  <= 1'b0;
      gate_q  <= 1'b1;
      pd_q    <= '1;
      fence_q <= HAS_FENCE;
    end else if (ctrl_en) begin
      en_a_q  <= en_a_d;
      en_b_q  <= en_b_d;
      iso_q   <= iso_d;
      rstn_q  <= rstn_d;
      gate_q  <= gate_d;
      pd_q    <= pd_d;
      fence_q <= fence_d;
    end
  end

  assign sw_en_a       = en_a_q;
  assign sw_en_b       = en_b_q;
  assign iso_en        = iso_q;
  assign dom_rst_n     = rstn_q;
  assign clk_gate      = gate_q;
  assign mem_pd        = pd_q;
  assign bus_fence_req = fence_q;
  assign busy          = (state_q != S_IDLE);
  assign done          = done_q;
  assign err           = err_q;

endmodule

// File: rtl/pwr_domain_seq_chk.sv
module pwr_domain_seq_chk #(
  parameter int MEM_BANKS   = 4,
  parameter int TIMEOUT_CYC = 1024
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sw_en_a,
  input logic                 sw_en_b,
  input logic                 iso_en,
  input logic                 dom_rst_n,
  input logic                 clk_gate,
  input logic [MEM_BANKS-1:0] mem_pd,
  input logic                 bus_fence_req,
  input logic                 busy,
  input logic                 done,
  input logic                 err
);

  logic [31:0] busy_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run_q <= '0;
    else if (busy) busy_run_q <= busy_run_q + 1'b1;
    else           busy_run_q <= '0;
  end

  AST_SWB_AFTER_SWA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en_b) |-> $past(sw_en_a));                                    // R1
  AST_ISO_OFF_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> (!clk_gate && sw_en_a && sw_en_b));                  // R3
  AST_RST_REL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dom_rst_n) |-> !iso_en);                                         // R3
  AST_MEM_ON_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_pd == '0) && $past(mem_pd != '0)) |-> dom_rst_n);                // R3
  AST_FENCE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_fence_req) |-> ((mem_pd == '0) && dom_rst_n));               // R5
  AST_ISO_AFTER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iso_en) |-> (mem_pd == '1));                                     // R6
  AST_SWA_OFF_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_en_a) |-> (clk_gate && !dom_rst_n && iso_en));                // R7
  AST_SWB_OFF_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_en_b) |-> !sw_en_a);                                          // R7
  AST_ERR_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (busy_run_q >= TIMEOUT_CYC));                                  // R8
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));                                                       // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                                       // R10

endmodule

bind pwr_domain_seq pwr_domain_seq_chk #(
  .MEM_BANKS  (MEM_BANKS),
  .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sw_en_a      (sw_en_a),
  .sw_en_b      (sw_en_b),
  .iso_en       (iso_en),
  .dom_rst_n    (dom_rst_n),
  .clk_gate     (clk_gate),
  .mem_pd       (mem_pd),
  .bus_fence_req(bus_fence_req),
  .busy         (busy),
  .done         (done),
  .err          (err)
);

// File: tb/pwr_domain_seq_bench.sv
`timescale 1ns/1ps
module pwr_domain_seq_bench;

  localparam int       NB  = 4;
  localparam logic [3:0] MSK = 4'b0011;
  localparam int       TMO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic on_req, off_req;
  logic stat_a, stat_b, fence_ack;
  logic [NB-1:0] mem_ack, m_mem;
  logic sw_a, sw_b, iso, drst_n, cgate, fence_req, busy, done, err;
  logic [NB-1:0] mem_pd;

  pwr_domain_seq #(.MEM_BANKS(NB), .MEM_ACK_MASK(MSK), .HAS_FENCE(1'b1),
                   .TIMEOUT_CYC(TMO)) u_pwr_domain_seq (
    .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
    .pwr_stat_a(stat_a), .pwr_stat_b(stat_b), .mem_pd_ack(mem_ack),
    .bus_fence_ack(fence_ack), .sw_en_a(sw_a), .sw_en_b(sw_b), .iso_en(iso),
    .dom_rst_n(drst_n), .clk_gate(cgate), .mem_pd(mem_pd),
    .bus_fence_req(fence_req), .busy(busy), .done(done), .err(err));

  // second island: no memory acks, no fence; acks tied to values that would block
  logic b_sa, b_sb, b_swa, b_swb, b_iso, b_rst, b_cg, b_fr, b_busy, b_done, b_err;
  logic [NB-1:0] b_pd;
  logic b_err_seen;

  pwr_domain_seq #(.MEM_BANKS(NB), .MEM_ACK_MASK(4'b0000), .HAS_FENCE(1'b0),
                   .TIMEOUT_CYC(TMO)) u_pwr_domain_seq_lite (
    .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
    .pwr_stat_a(b_sa), .pwr_stat_b(b_sb), .mem_pd_ack(4'hF),
    .bus_fence_ack(1'b1), .sw_en_a(b_swa), .sw_en_b(b_swb), .iso_en(b_iso),
    .dom_rst_n(b_rst), .clk_gate(b_cg), .mem_pd(b_pd),
    .bus_fence_req(b_fr), .busy(b_busy), .done(b_done), .err(b_err));

  // island model with programmable delays and stuck controls
  logic [7:0] sh_a, sh_b, sh_f;
  logic [7:0][NB-1:0] sh_m;
  int d_a, d_b, d_m, d_f;
  logic hold_b, hold_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_a <= '0; sh_b <= '0; sh_f <= '1; sh_m <= '1;
      stat_a <= 1'b0; stat_b <= 1'b0; fence_ack <= 1'b1; m_mem <= '1;
      b_sa <= 1'b0; b_sb <= 1'b0; b_err_seen <= 1'b0;
    end else begin
      sh_a <= {sh_a[6:0], sw_a};
      sh_b <= {sh_b[6:0], sw_b};
      sh_f <= {sh_f[6:0], fence_req};
      sh_m <= {sh_m[6:0], mem_pd};
      stat_a <= sh_a[d_a];
      if (!hold_b) stat_b <= sh_b[d_b];
      if (!hold_f) fence_ack <= sh_f[d_f];
      m_mem <= sh_m[d_m];
      b_sa <= b_swa;
      b_sb <= b_swb;
      if (b_err) b_err_seen <= 1'b1;
    end
  end
  // unmasked banks answer 1 forever, which must not block power-up
  assign mem_ack = (m_mem & MSK) | ~MSK;

  // change-time stamps
  int cyc = 0;
  int t_a, t_b, t_sa, t_sb, t_iso, t_rst, t_cg, t_pd, t_fr, t_fa, t_mack;
  logic p_a, p_b, p_sa, p_sb, p_iso, p_rst, p_cg, p_fr, p_fa;
  logic [NB-1:0] p_pd, p_mack;
  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (sw_a !== p_a) t_a = cyc;
    if (sw_b !== p_b) t_b = cyc;
    if (stat_a !== p_sa) t_sa = cyc;
    if (stat_b !== p_sb) t_sb = cyc;
    if (iso !== p_iso) t_iso = cyc;
    if (drst_n !== p_rst) t_rst = cyc;
    if (cgate !== p_cg) t_cg = cyc;
    if (mem_pd !== p_pd) t_pd = cyc;
    if (fence_req !== p_fr) t_fr = cyc;
    if (fence_ack !== p_fa) t_fa = cyc;
    if ((mem_ack & MSK) !== p_mack) t_mack = cyc;
    p_a = sw_a; p_b = sw_b; p_sa = stat_a; p_sb = stat_b; p_iso = iso;
    p_rst = drst_n; p_cg = cgate; p_pd = mem_pd; p_fr = fence_req;
    p_fa = fence_ack; p_mack = mem_ack & MSK;
  end

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_out(input bit on);
    return on ? {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0}
              : {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 1'b1};
  endfunction

  function automatic logic [9:0] act_out();
    return {sw_a, sw_b, iso, drst_n, cgate, mem_pd, fence_req};
  endfunction

  task automatic pulse(input bit on, input bit off);
    @(negedge clk);
    on_req = on; off_req = off;
    @(negedge clk);
    on_req = 1'b0; off_req = 1'b0;
  endtask

  task automatic wait_end(output int res, output int n);
    res = 2; n = 0;
    while (res == 2 && n < 3000) begin
      if (done) res = 0;
      else if (err) res = 1;
      else begin @(negedge clk); n++; end
    end
  endtask

  int  res, n, dummy;
  bit  model_on;
  logic [9:0] snap;

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    dummy = $urandom(32'd4242);
    on_req = 0; off_req = 0;
    d_a = 1; d_b = 3; d_m = 2; d_f = 1; hold_b = 0; hold_f = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk(act_out() == exp_out(0), "R9 outputs", act_out(), exp_out(0));
    chk({busy, done, err} == 3'b000, "R9 status", {busy, done, err}, 0);
    chk(b_fr == 1'b0, "R9 fence off when unused", b_fr, 0);

    // R1 R2 R3 R4 R5 power-up
    pulse(1, 0);
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    wait_end(res, n);
    chk(res == 0, "R10 power-up done", res, 0);
    chk(act_out() == exp_out(1), "R3 on pattern", act_out(), exp_out(1));
    chk(t_a < t_b, "R1 switch a before b", t_a, t_b);
    chk(t_cg > t_sa && t_cg > t_sb, "R2 wait both status", t_cg, t_sb);
    chk(t_cg < t_iso && t_iso < t_rst && t_rst < t_pd, "R3 order", t_iso, t_rst);
    chk(t_fr > t_mack, "R4 mem ack wait before fence", t_fr, t_mack);
    chk(t_fr > t_pd, "R5 fence drop last", t_fr, t_pd);
    chk({b_swa, b_swb, b_iso, b_rst, b_cg, b_pd, b_fr} == exp_out(1) && !b_err_seen,
        "R4 R5 lite island on", {b_swa, b_swb, b_iso, b_rst, b_cg, b_pd, b_fr}, exp_out(1));

    // R11 redundant on
    snap = act_out();
    pulse(1, 0);
    chk(done == 1'b1 && busy == 1'b0, "R11 redundant on done", {done, busy}, 2'b10);
    chk(act_out() == snap, "R11 no output change", act_out(), snap);

    // R5 R6 R7 power-down
    pulse(0, 1);
    wait_end(res, n);
    chk(res == 0, "R7 power-down done", res, 0);
    chk(act_out() == exp_out(0), "R7 off pattern", act_out(), exp_out(0));
    chk(t_pd > t_fa && t_fa > t_fr, "R5 fence first", t_pd, t_fa);
    chk(t_iso > t_mack && t_mack > t_pd, "R6 mem acks before iso", t_iso, t_mack);
    chk(t_iso < t_rst && t_rst < t_cg && t_cg < t_a && t_a < t_b, "R7 order", t_cg, t_a);

    // R11 redundant off, then both together
    pulse(0, 1);
    chk(done == 1'b1 && busy == 1'b0, "R11 redundant off", {done, busy}, 2'b10);
    pulse(1, 1);
    wait_end(res, n);
    chk(res == 0 && act_out() == exp_out(1), "R11 on wins", act_out(), exp_out(1));

    // R10 ignored request during power-down
    pulse(0, 1);
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R10 busy mid sequence", busy, 1);
    pulse(1, 0);
    wait_end(res, n);
    chk(res == 0 && act_out() == exp_out(0), "R10 request ignored", act_out(), exp_out(0));

    // R2 R8 one status line stuck low
    hold_b = 1'b1;
    pulse(1, 0);
    wait_end(res, n);
    chk(res == 1, "R2 single status times out", res, 1);
    chk(n >= TMO, "R8 not early", n, TMO);
    chk({sw_a, sw_b, iso, drst_n, cgate, busy} == 6'b111010, "R8 outputs held",
        {sw_a, sw_b, iso, drst_n, cgate, busy}, 6'b111010);
    @(negedge clk);
    chk(err == 1'b0, "R8 err one cycle", err, 0);
    hold_b = 1'b0;
    repeat (10) @(negedge clk);
    pulse(1, 0);
    wait_end(res, n);
    chk(res == 0 && act_out() == exp_out(1), "R8 retry after abort", act_out(), exp_out(1));

    // R5 R8 fence ack never comes
    hold_f = 1'b1;
    pulse(0, 1);
    wait_end(res, n);
    chk(res == 1, "R5 fence wait times out", res, 1);
    chk(fence_req == 1'b1 && mem_pd == 4'h0 && iso == 1'b0, "R8 stopped at fence",
        {fence_req, mem_pd, iso}, 6'b100000);
    hold_f = 1'b0;
    repeat (10) @(negedge clk);
    pulse(0, 1);
    wait_end(res, n);
    chk(res == 0 && act_out() == exp_out(0), "R8 off retry", act_out(), exp_out(0));
    model_on = 1'b0;

    // R10 R11 random requests and island delays
    for (int i = 0; i < 40; i++) begin
      int r;
      d_a = $urandom_range(0, 5); d_b = $urandom_range(0, 5);
      d_m = $urandom_range(0, 5); d_f = $urandom_range(0, 5);
      repeat (8) @(negedge clk);
      r = $urandom_range(0, 3);
      if (r == 1) begin pulse(0, 1); model_on = 1'b0; end
      else if (r == 2) begin pulse(1, 1); model_on = 1'b1; end
      else begin pulse(1, 0); model_on = 1'b1; end
      if ($urandom_range(0, 1) == 1 && busy) begin
        pulse(r != 1, r == 1);
      end
      wait_end(res, n);
      chk(res == 0 && act_out() == exp_out(model_on), "R10 random sequence",
          act_out(), exp_out(model_on));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule